// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a triple 8-bit voltage DAC with a parallel bus. It takes one command at a time over a valid/ready handshake. A command names a channel and carries an 8-bit code. Channel values 0 to 2 load that DAC channel. Channel value 3 is the power-down request. For every command the block drives the DAC address and data lines and pulses the active-low write strobe.

The bus timing margins are parameters given in picoseconds. Each one becomes a whole number of clock cycles. The address and data go onto the bus together, some cycles before the strobe falls. They stay unchanged until a hold interval after the strobe rises.

The block keeps track of whether the DAC is powered down. After a channel write it raises a settled flag once the output has had time to settle. After a write that wakes the DAC it raises the flag only once the longer wake recovery time has passed.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset the strobe is high, ready is high, settled is high, the address and data outputs are 0, and the DAC is taken to be awake.
- R2: On acceptance of a command, the channel and code appear on the address and data outputs. The strobe falls exactly ASET cycles after the accepting edge. The address and data do not change from acceptance until HOLD cycles after the strobe rises. ASET is the address setup time rounded up to cycles, with a minimum of 1.
- R3: The strobe stays low for exactly LOW cycles. LOW is the larger of the pulse-width count and the data-setup count minus ASET, with a minimum of 1. With the default 8 ns clock this gives ASET=1, LOW=3 and HOLD=1.
- R4: Ready goes low on the accepting edge and returns high exactly ASET+LOW+HOLD cycles later. The strobe is never low while ready is high.
- R5: Settled goes low on the accepting edge. If the DAC is awake, a write to channel 0, 1 or 2 raises settled exactly SETTLE cycles after the strobe fall. SETTLE is 6 µs in cycles, which is 750 at 8 ns.
- R6: A command with channel value 3 is written with address 3 and puts the DAC in power-down. Settled then stays low until a later channel write has recovered.
- R7: The first channel write after power-down wakes the DAC. It raises settled exactly WAKE cycles after its strobe fall. WAKE is 13 µs in cycles, which is 1625 at 8 ns.
- R8: A channel write accepted while wake recovery is still pending also waits WAKE cycles from its own strobe fall.
- R9: Every count is the time divided by the clock period, rounded up, with a minimum of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_chan | input | 2 | Channel 0 to 2, or 3 for power-down |
| cmd_code | input | 8 | Code to load |
| dac_addr | output | 2 | DAC address lines |
| dac_data | output | 8 | DAC data lines |
| dac_wr_n | output | 1 | Active-low write strobe |
| settled | output | 1 | Output settled or recovered |

## Verification
The hardest case to reach from the ports is a second channel write that arrives while wake recovery is still pending. To reach it, the bench powers the DAC down and wakes it with one write. About twenty cycles later it issues a further write, long before the 1625-cycle recovery could end. It then checks that settled stays low for the full wake count, measured from the second strobe fall. A sweep of every code on every channel is also run back to back, so that each new command restarts the settle wait before the previous one can finish.

// File: rtl/dac_wr_seq.sv
module dac_wr_seq #(
  parameter int CLK_PS      = 8000,
  parameter int ASU_PS      = 5000,
  parameter int DSU_PS      = 25000,
  parameter int PW_PS       = 20000,
  parameter int HOLD_PS     = 0,
  parameter int SETTLE_PS   = 6000000,
  parameter int WAKE_PS     = 13000000,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_chan,
  input  logic [DW-1:0] cmd_code,
  output logic [1:0]    dac_addr,
  output logic [DW-1:0] dac_data,
  output logic          dac_wr_n,
  output logic          settled
);
  localparam int A0 = (ASU_PS + CLK_PS - 1) / CLK_PS;
  localparam int D0 = (DSU_PS + CLK_PS - 1) / CLK_PS;
  localparam int P0 = (PW_PS + CLK_PS - 1) / CLK_PS;
  localparam int H0 = (HOLD_PS + CLK_PS - 1) / CLK_PS;
  localparam int S0 = (SETTLE_PS + CLK_PS - 1) / CLK_PS;
  localparam int W0 = (WAKE_PS + CLK_PS - 1) / CLK_PS;
  localparam int ASET = (A0 < 1) ? 1 : A0;
  localparam int HOLD = (H0 < 1) ? 1 : H0;
  localparam int SETC = (S0 < 1) ? 1 : S0;
  localparam int WAKC = (W0 < 1) ? 1 : W0;
  localparam int L0   = (P0 > D0 - ASET) ? P0 : D0 - ASET;
  localparam int LOW  = (L0 < 1) ? 1 : L0;
  localparam int CMAX = (ASET > LOW) ? ((ASET > HOLD) ? ASET : HOLD) : ((LOW > HOLD) ? LOW : HOLD);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TMAX = (WAKC > SETC) ? WAKC : SETC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {IDLE, SETUP, STRB, HOLDS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic          asleep, waking;

  assign cmd_ready = (st == IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      tmr <= '0;
      dac_addr <= '0;
      dac_data <= '0;
      dac_wr_n <= 1'b1;
      asleep <= 1'b0;
      waking <= 1'b0;
      settled <= 1'b1;
    end else begin
      if (tmr != '0) begin
        tmr <= tmr - 1'b1;
        if (tmr == TW'(1)) begin
          settled <= 1'b1;
          waking <= 1'b0;
        end
      end
      case (st)
        IDLE: if (cmd_valid) begin
          dac_addr <= cmd_chan;
          dac_data <= cmd_code;
          settled <= 1'b0;
          tmr <= '0;
          cnt <= CW'(ASET - 1);
          st <= SETUP;
        end
        SETUP: if (cnt == '0) begin
          dac_wr_n <= 1'b0;
          cnt <= CW'(LOW - 1);
          st <= STRB;
          if (dac_addr == 2'd3) begin
            asleep <= 1'b1;
            waking <= 1'b0;
          end else begin
            tmr <= (asleep || waking) ? TW'(WAKC) : TW'(SETC);
            waking <= asleep || waking;
            asleep <= 1'b0;
          end
        end else cnt <= cnt - 1'b1;
        STRB: if (cnt == '0) begin
          dac_wr_n <= 1'b1;
          cnt <= CW'(HOLD - 1);
          st <= HOLDS;
        end else cnt <= cnt - 1'b1;
        HOLDS: if (cnt == '0) st <= IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module dac_wr_seq_chk #(
  parameter int CLK_PS = 8000,
  parameter int PW_PS  = 20000,
  parameter int DW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    dac_addr,
  input logic [DW-1:0] dac_data,
  input logic          dac_wr_n,
  input logic          settled
);
  localparam int P0 = (PW_PS + CLK_PS - 1) / CLK_PS;
  localparam int PMIN = (P0 < 1) ? 1 : P0;
  logic [15:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowcnt <= '0;
    else if (!dac_wr_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;

  p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));
  p_setup_before_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));
  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (lowcnt >= 16'(PMIN)));
  p_no_strobe_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> dac_wr_n);
  p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!settled && !cmd_ready));
endmodule

bind dac_wr_seq dac_wr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n), .settled(settled)
);

// File: tb/test_dac_wr_seq.sv
module test_dac_wr_seq;
  localparam int CLK_PS = 8000;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ASET = cyc(5000);
  localparam int PWC  = cyc(20000);
  localparam int DSC  = cyc(25000);
  localparam int LOW  = (PWC > DSC - ASET) ? PWC : ((DSC - ASET < 1) ? 1 : DSC - ASET);
  localparam int HOLD = cyc(0);
  localparam int SETC = cyc(6000000);
  localparam int WAKC = cyc(13000000);
  localparam int BUSY = ASET + LOW + HOLD;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_chan = 0;
  logic [7:0] cmd_code = 0;
  logic cmd_ready, dac_wr_n, settled;
  logic [1:0] dac_addr;
  logic [7:0] dac_data;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  dac_wr_seq i_dac_wr_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_code(cmd_code), .dac_addr(dac_addr),
    .dac_data(dac_data), .dac_wr_n(dac_wr_n), .settled(settled)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cmd(input logic [1:0] ch, input logic [7:0] cd, input int obs, input int tset);
    int lim;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_chan = ch; cmd_code = cd;
    @(negedge clk);
    cmd_valid = 0; cmd_chan = ~ch; cmd_code = ~cd;
    lim = (obs == 0) ? BUSY : obs;
    for (int k = 0; k < lim; k++) begin
      chk("R3 strobe", dac_wr_n, !(k >= ASET && k < ASET + LOW));
      chk("R4 ready", cmd_ready, k >= BUSY);
      if (k < BUSY) begin
        chk("R2 addr", dac_addr, ch);
        chk("R2 data", dac_data, cd);
      end
      chk(tset == WAKC ? "R7 R8 settled" : (tset == 0 ? "R6 settled" : "R5 settled"),
          settled, (tset > 0) && (k >= ASET + tset));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_n", dac_wr_n, 1);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 settled", settled, 1);
    chk("R1 addr", dac_addr, 0);
    chk("R1 data", dac_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 counts", BUSY * 1000 + LOW, 5003);
    run_cmd(2'd1, 8'h5a, ASET + SETC + 2, SETC);
    for (int c = 0; c < 3; c++)
      for (int v = 0; v < 256; v++)
        run_cmd(c[1:0], v[7:0], 0, 0);
    run_cmd(2'd2, 8'hff, ASET + SETC + 2, SETC);
    run_cmd(2'd3, 8'h00, ASET + WAKC + 20, 0);
    run_cmd(2'd0, 8'h80, ASET + WAKC + 2, WAKC);
    run_cmd(2'd1, 8'h7f, ASET + SETC + 2, SETC);
    run_cmd(2'd3, 8'h11, ASET + 30, 0);
    run_cmd(2'd2, 8'h01, ASET + 20, 0);
    run_cmd(2'd0, 8'hfe, ASET + WAKC + 2, WAKC);
    run_cmd(2'd2, 8'h33, ASET + SETC + 2, SETC);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule